// File: doc/BRIEF.md
# Snooze Entry and Wake Sequencer

This block runs the low-power snooze state of a synchronous memory core. An external sleep request arrives with no relation to the clock. The block passes it through a synchronizer and then times a fixed entry delay. When that delay ends, it tells the core to ignore every synchronous input. When the request is withdrawn, it times a fixed wake-up delay before the core may sample inputs again. The storage array is not touched, so its contents and internal state survive the whole episode.

While an entry is in progress, a forced-deselect output tells the core to stop starting new accesses. This gives an operation that is already running a chance to drain. If the core still reports a write in flight at the moment sleep takes hold, a one-cycle warning is raised, because that operation may not complete. A request that drops before entry completes cancels the entry. A request that rises again during wake-up sends the block straight back to sleep.

Top module: `snooze_seq`

## Requirements
- R1: While reset is asserted, every output is low. At the first clock edge after reset is released, `ready` goes high and the other outputs stay low.
- R2: The request passes through two synchronizer stages and then an entry delay of two cycles. If the request is first sampled high at edge k, `ignore_inputs` and `asleep` go high at edge k+4 and not earlier.
- R3: `force_desel` goes high at edge k+2, two edges before `ignore_inputs`, and `ready` falls at the same edge.
- R4: While asleep, `ignore_inputs` and `force_desel` stay high for as long as the request stays high. `asleep` implies `ignore_inputs`, and `ignore_inputs` implies `force_desel`.
- R5: If the request is first sampled low at edge k while asleep, `asleep` falls at edge k+2. `ignore_inputs` stays high through the two wake-up cycles, falls at edge k+4, and `ready` rises at that same edge.
- R6: A request that is sampled low before the entry delay ends cancels the entry. `ignore_inputs` never rises, and `force_desel` falls and `ready` rises together at the edge where the cancel takes effect.
- R7: After a cancel, the next request runs the full entry delay again from the start.
- R8: A request that returns high during the wake-up delay sends the block back to `asleep`. `ready` stays low and `ignore_inputs` stays high throughout.
- R9: `busy_warn` is a one-cycle pulse at the edge where `asleep` rises from an entry, and only if `core_busy` is high at that edge. If `core_busy` is low, there is no pulse.
- R10: `ready` and `ignore_inputs` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req_raw | input | 1 | Asynchronous active-high snooze request |
| core_busy | input | 1 | Core has a write still in flight |
| ignore_inputs | output | 1 | Core must ignore all synchronous inputs |
| force_desel | output | 1 | Core must act as deselected and start no access |
| asleep | output | 1 | Snooze state fully entered |
| ready | output | 1 | Core may operate normally |
| busy_warn | output | 1 | Pulse: sleep began with a write still in flight |

## Verification
Most internal faults show up as an edge that arrives at the wrong time. A wrong synchronizer depth or a wrong delay count moves the rising edge of `ignore_inputs`, or the rising edge of `ready`, by one or more cycles, and this is visible within four cycles of the request changing. A state machine that misses a cancel or a re-entry leaves `ignore_inputs` high when `ready` should be high, or drops it during a wake-up that should have been aborted. A faulty `busy_warn` shows at the one edge where sleep takes hold.

// File: rtl/snooze_pkg.sv
package snooze_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } snooze_state_e;

endpackage

// File: rtl/snooze_sync.sv
module snooze_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  // chain[0] takes the raw pin; each later stage copies the one before it.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/snooze_cnt.sv
module snooze_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt;

  // load wins over dec; the count stops at zero.
  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/snooze_fsm.sv
module snooze_fsm
  import snooze_pkg::*;
#(
  parameter int ENTRY_CYCLES = 2,
  parameter int WAKE_CYCLES  = 2,
  parameter int CNT_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_s,
  input  logic             core_busy,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic             cnt_dec,
  output logic             ignore_q,
  output logic             desel_q,
  output logic             asleep_q,
  output logic             ready_q,
  output logic             warn_q
);

  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAKE_LOAD  = CNT_W'(WAKE_CYCLES - 1);

  snooze_state_e state, nxt;

  // Next state. In the two timed states the request level is checked
  // before the counter, so a cancel or an abort is never lost.
  always_comb begin
    nxt          = state;
    cnt_load     = 1'b0;
    cnt_load_val = ENTRY_LOAD;
    cnt_dec      = 1'b0;
    unique case (state)
      ST_AWAKE: begin
        if (req_s) begin
          nxt          = ST_ENTER;
          cnt_load     = 1'b1;
          cnt_load_val = ENTRY_LOAD;
        end
      end
      ST_ENTER: begin
        if (!req_s)        nxt = ST_AWAKE;
        else if (cnt_zero) nxt = ST_SLEEP;
        else               cnt_dec = 1'b1;
      end
      ST_SLEEP: begin
        if (!req_s) begin
          nxt          = ST_WAKE;
          cnt_load     = 1'b1;
          cnt_load_val = WAKE_LOAD;
        end
      end
      ST_WAKE: begin
        if (req_s)         nxt = ST_SLEEP;
        else if (cnt_zero) nxt = ST_AWAKE;
        else               cnt_dec = 1'b1;
      end
      default: nxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_AWAKE;
    else     state <= nxt;
  end

  // Every output is a register fed from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      ignore_q <= 1'b0;
      desel_q  <= 1'b0;
      asleep_q <= 1'b0;
      ready_q  <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      ignore_q <= (nxt == ST_SLEEP) || (nxt == ST_WAKE);
      desel_q  <= (nxt != ST_AWAKE);
      asleep_q <= (nxt == ST_SLEEP);
      ready_q  <= (nxt == ST_AWAKE);
      warn_q   <= (state == ST_ENTER) && (nxt == ST_SLEEP) && core_busy;
    end
  end

endmodule

// File: rtl/snooze_seq.sv
module snooze_seq #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int WAKE_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req_raw,
  input  logic core_busy,
  output logic ignore_inputs,
  output logic force_desel,
  output logic asleep,
  output logic ready,
  output logic busy_warn
);

  localparam int MAX_DELAY = (ENTRY_CYCLES > WAKE_CYCLES) ? ENTRY_CYCLES : WAKE_CYCLES;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);

  logic             req_s;
  logic             cnt_load;
  logic             cnt_dec;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt_load_val;

  snooze_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sleep_req_raw),
    .q_sync  (req_s)
  );

  snooze_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  snooze_fsm #(
    .ENTRY_CYCLES (ENTRY_CYCLES),
    .WAKE_CYCLES  (WAKE_CYCLES),
    .CNT_W        (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_s        (req_s),
    .core_busy    (core_busy),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_dec      (cnt_dec),
    .ignore_q     (ignore_inputs),
    .desel_q      (force_desel),
    .asleep_q     (asleep),
    .ready_q      (ready),
    .warn_q       (busy_warn)
  );

endmodule

// File: rtl/snooze_seq_chk.sv
module snooze_seq_chk #(
  parameter int ENTRY_CYCLES = 2,
  parameter int WAKE_CYCLES  = 2
) (
  input logic clk,
  input logic rst,
  input logic ignore_inputs,
  input logic force_desel,
  input logic asleep,
  input logic ready,
  input logic busy_warn
);

  logic [15:0] enter_run;
  logic [15:0] wake_run;

  // Run lengths of the entry phase and the wake-up phase, both seen at
  // the ports. Each saturates instead of wrapping.
  always_ff @(posedge clk) begin
    if (rst) begin
      enter_run <= '0;
      wake_run  <= '0;
    end else begin
      if (force_desel && !ignore_inputs) enter_run <= (enter_run == 16'hFFFF) ? enter_run : enter_run + 1'b1;
      else                               enter_run <= '0;
      if (ignore_inputs && !asleep)      wake_run  <= (wake_run == 16'hFFFF) ? wake_run : wake_run + 1'b1;
      else                               wake_run  <= '0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!ignore_inputs && !force_desel && !asleep && !busy_warn));

  assert_entry_span_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(asleep) && !$past(ignore_inputs)) |-> (enter_run == 16'(ENTRY_CYCLES)));

  assert_ignore_desel_R4: assert property (@(posedge clk) disable iff (rst)
    ignore_inputs |-> force_desel);

  assert_asleep_ignore_R4: assert property (@(posedge clk) disable iff (rst)
    asleep |-> ignore_inputs);

  assert_wake_span_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && $past(ignore_inputs)) |-> (wake_run == 16'(WAKE_CYCLES)));

  assert_desel_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(force_desel) |-> ready);

  assert_warn_on_entry_R9: assert property (@(posedge clk) disable iff (rst)
    busy_warn |-> $rose(asleep));

  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(ready && ignore_inputs));

endmodule

bind snooze_seq snooze_seq_chk #(
  .ENTRY_CYCLES (ENTRY_CYCLES),
  .WAKE_CYCLES  (WAKE_CYCLES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ignore_inputs (ignore_inputs),
  .force_desel   (force_desel),
  .asleep        (asleep),
  .ready         (ready),
  .busy_warn     (busy_warn)
);

// File: tb/snooze_seq_bench.sv
module snooze_seq_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req_raw = 1'b0;
  logic core_busy = 1'b0;
  logic ignore_inputs, force_desel, asleep, ready, busy_warn;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  snooze_seq u_snooze_seq (
    .clk           (clk),
    .rst           (rst),
    .sleep_req_raw (sleep_req_raw),
    .core_busy     (core_busy),
    .ignore_inputs (ignore_inputs),
    .force_desel   (force_desel),
    .asleep        (asleep),
    .ready         (ready),
    .busy_warn     (busy_warn)
  );

  // Inputs change and outputs are read at the falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic ig, input logic fd,
                         input logic sl, input logic rd, input logic wn);
    chk(tag, "ignore_inputs", ignore_inputs, ig);
    chk(tag, "force_desel",   force_desel,   fd);
    chk(tag, "asleep",        asleep,        sl);
    chk(tag, "ready",         ready,         rd);
    chk(tag, "busy_warn",     busy_warn,     wn);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    sleep_req_raw = 1'b1;
    tick(); tick(); tick();
    chk_all("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    sleep_req_raw = 1'b0;
    tick();
    rst = 1'b0;
    tick();
    chk_all("R1 after release", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    tick(); tick();
  endtask

  // Full entry. The request is first sampled at edge 0.
  task automatic t_enter(input string tag, input logic busy);
    core_busy = busy;
    sleep_req_raw = 1'b1;
    tick(); tick();                                 // edges 0,1
    chk_all({tag, " edge1"}, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    tick();                                         // edge 2
    chk_all({tag, " R3 edge2"}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 3
    chk_all({tag, " R2 edge3"}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 4
    chk_all({tag, " R2 R9 edge4"}, 1'b1, 1'b1, 1'b1, 1'b0, busy);
    tick();                                         // edge 5
    chk_all({tag, " R9 edge5"}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    core_busy = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    chk_all({tag, " R4 hold"}, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_wake();
    sleep_req_raw = 1'b0;
    tick(); tick();                                 // edges 0,1
    chk_all("R5 edge1", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    tick();                                         // edge 2
    chk_all("R5 edge2", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 3
    chk_all("R5 R10 edge3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 4
    chk_all("R5 edge4", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    tick(); tick();
  endtask

  task automatic t_cancel();
    sleep_req_raw = 1'b1;
    tick(); tick();                                 // sampled high at edges 0,1
    sleep_req_raw = 1'b0;
    tick();                                         // edge 2
    chk_all("R6 entering", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 3
    chk_all("R6 edge3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 4: cancel takes effect
    chk_all("R6 cancelled", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R6 stays awake", "ignore_inputs", ignore_inputs, 1'b0);
    end
  endtask

  task automatic t_wake_abort();
    sleep_req_raw = 1'b0;
    tick(); tick();                                 // low at edges 0,1
    sleep_req_raw = 1'b1;
    tick();                                         // edge 2: wake-up starts
    chk_all("R8 waking", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 3
    chk_all("R8 edge3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    tick();                                         // edge 4: back asleep
    chk_all("R8 re-asleep", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 stays asleep", "ready", ready, 1'b0);
    end
    chk_all("R8 final", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enter("R2 quiet entry", 1'b0);
    t_wake();
    t_cancel();
    t_enter("R7 reload entry", 1'b0);
    t_wake();
    t_enter("R9 busy entry", 1'b1);
    t_wake_abort();
    t_wake();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule